// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block divides a fast clock by a programmable integer for the feedback path of a phase-locked loop. It emits one single-clock pulse per divide period. A prescaler that counts either 8 or 9 input clocks drives two down-counters. The swallow counter keeps the prescaler at 9 for the first A prescaler periods. The main counter counts M prescaler periods in total. One output period is therefore 8·M + A input clocks. All logic is synchronous to the one input clock.

The 14-bit divide word is split into two fields. The low three bits give A and the upper eleven bits give M. The scheme needs M ≥ A and M ≥ 1, so some ratios below 56 cannot be reached. From 56 up to 16383, every integer ratio is reachable. An illegal word raises an error flag and silences the output. A legal word is taken only on reset or at the end of a full period, so no period is ever cut short or stretched.

Top module: `swallow_fb_divider`

## Requirements
- R1: For a legal word, consecutive output pulses are exactly 8·M + A input clocks apart. A is `divWord[2:0]` and M is `divWord[13:3]`.
- R2: With A equal to M, every prescaler period lasts 9 clocks, so the ratio is 9·M (for example 9 and 63).
- R3: `divPulse` is high for exactly one clock per period.
- R4: After reset with a legal word, the first pulse rises on the P-th rising edge after the last edge that saw reset high, where P = 8·M + A.
- R5: A word with M = 0 or M < A sets `cfgErr` from the edge that loads it and keeps `divPulse` low for as long as it is held.
- R6: While `cfgErr` is high, the word is sampled on every clock. The edge that samples a legal word clears `cfgErr`, and the first pulse follows P edges after that edge.
- R7: A word change in the middle of a period leaves that period unchanged. The new ratio (or the error state) takes effect at the edge that ends the period, and that edge still produces the pulse.
- R8: The largest ratio, 16383 (M = 2047, A = 7), and the smallest legal ratios above and below 56 give their exact periods.
- R9: Reset is synchronous and active-high. `divPulse` stays low while reset is asserted, even when reset arrives in the middle of a period, and counting restarts after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| divWord | input | 14 | Divide control: [2:0] swallow count A, [13:3] main count M |
| divPulse | output | 1 | One-clock registered pulse per divide period |
| cfgErr | output | 1 | High while the held divide word is illegal |

## Verification
Each result is due a fixed number of clocks after the edge that loads a word: the first pulse P edges later, and every later pulse P edges after the one before it. `cfgErr` follows on the loading edge itself. The bench changes inputs and samples only at falling edges. It counts falling edges from the sample just after the loading edge (or just after the previous pulse) and expects the pulse exactly at count P, never earlier and never later. For changes in the middle of a period, the expected count is the old ratio minus the clocks already elapsed, followed by the new ratio.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

  // Strobes sent from the control to the counter datapath.
  typedef struct packed {
    logic load;  // restart: reload counters from the divide word
    logic step;  // advance the prescaler and counters by one clock
  } divStrobe_t;

endpackage

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
  import swallow_div_pkg::*;
#(
  parameter int PRE_N = 8,
  parameter int M_W   = 11,
  localparam int A_W  = $clog2(PRE_N),
  localparam int CW   = A_W + M_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] divWord,
  input  logic          lastNow,
  output divStrobe_t    strb,
  output logic          cfgBad,
  output logic          divPulse
);

  logic [A_W-1:0] wordA;
  logic [M_W-1:0] wordM;
  logic           wordBad;

  assign wordA   = divWord[A_W-1:0];
  assign wordM   = divWord[CW-1:A_W];
  assign wordBad = (wordM == '0) || (wordM < M_W'(wordA));

  // A word is taken on reset, at a period end, or every clock while illegal.
  always_comb begin
    strb.load = rst | cfgBad | lastNow;
    strb.step = ~strb.load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgBad   <= wordBad;
      divPulse <= 1'b0;
    end else begin
      divPulse <= lastNow & ~cfgBad;
      if (strb.load) cfgBad <= wordBad;
    end
  end

  // R3: pulse is one clock wide
  a_r3_one_clock: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R5: no pulse follows a cycle that held an illegal word
  a_r5_silent_when_bad: assert property (@(posedge clk) disable iff (rst)
    $past(cfgBad) |-> !divPulse);

endmodule

// File: rtl/swallow_div_datapath.sv
module swallow_div_datapath
  import swallow_div_pkg::*;
#(
  parameter int PRE_N = 8,
  parameter int M_W   = 11,
  localparam int A_W  = $clog2(PRE_N),
  localparam int PC_W = $clog2(PRE_N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  divStrobe_t     strb,
  input  logic [A_W-1:0] loadA,
  input  logic [M_W-1:0] loadM,
  input  logic           cfgBad,
  output logic           lastNow
);

  localparam logic [PC_W-1:0] TERM_SLOW = PC_W'(PRE_N);      // modulus N+1
  localparam logic [PC_W-1:0] TERM_FAST = PC_W'(PRE_N - 1);  // modulus N

  logic [PC_W-1:0] preCnt;
  logic [A_W-1:0]  aLeft;
  logic [M_W-1:0]  mLeft;
  logic [PC_W-1:0] preTerm;
  logic            preEnd;

  // Prescaler stays at N+1 while swallow counts remain.
  assign preTerm = (aLeft != '0) ? TERM_SLOW : TERM_FAST;
  assign preEnd  = (preCnt == preTerm);
  assign lastNow = preEnd && (mLeft == M_W'(1));

  always_ff @(posedge clk) begin
    if (strb.load) begin
      preCnt <= '0;
      aLeft  <= loadA;
      mLeft  <= loadM;
    end else if (strb.step) begin
      if (preEnd) begin
        preCnt <= '0;
        if (aLeft != '0) aLeft <= aLeft - 1'b1;
        mLeft <= mLeft - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R2: prescaler never counts past its N+1 terminal value
  a_r2_prescaler_range: assert property (@(posedge clk) disable iff (rst)
    preCnt <= TERM_SLOW);

  // R2: once swallowing is done the prescaler runs at modulus N
  a_r2_fast_after_swallow: assert property (@(posedge clk) disable iff (rst)
    (aLeft == '0) |-> (preCnt <= TERM_FAST));

  // R1: with a legal word the main count never runs out before the swallow count
  a_r1_main_covers_swallow: assert property (@(posedge clk) disable iff (rst)
    !cfgBad |-> (mLeft != '0) && (M_W'(aLeft) <= mLeft));

endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
  import swallow_div_pkg::*;
#(
  parameter int PRE_N = 8,
  parameter int M_W   = 11,
  localparam int A_W  = $clog2(PRE_N),
  localparam int CW   = A_W + M_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] divWord,
  output logic          divPulse,
  output logic          cfgErr
);

  divStrobe_t strb;
  logic       lastNow;
  logic       cfgBad;

  swallow_div_ctrl #(.PRE_N(PRE_N), .M_W(M_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .divWord  (divWord),
    .lastNow  (lastNow),
    .strb     (strb),
    .cfgBad   (cfgBad),
    .divPulse (divPulse)
  );

  swallow_div_datapath #(.PRE_N(PRE_N), .M_W(M_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .loadA   (divWord[A_W-1:0]),
    .loadM   (divWord[CW-1:A_W]),
    .cfgBad  (cfgBad),
    .lastNow (lastNow)
  );

  assign cfgErr = cfgBad;

endmodule

// File: tb/sim_swallow_fb_divider.sv
module sim_swallow_fb_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] word = '0;
  logic        divPulse;
  logic        cfgErr;
  int          nPass = 0;
  int          nTotal = 0;
  bit          done = 0;

  always #4 clk = ~clk;  // 125 MHz

  swallow_fb_divider u0 (
    .clk(clk), .rst(rst), .divWord(word), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  function automatic logic [13:0] mk(input int m, input int a);
    return {11'(m), 3'(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTotal++;
    if (ok) nPass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  // Reset with word w; returns at the falling edge after the last reset edge.
  task automatic setup(input logic [13:0] w);
    @(negedge clk);
    rst  = 1'b1;
    word = w;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Count falling edges until a pulse is seen (or lim is reached).
  task automatic countTo(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!divPulse && n < lim);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nTotal++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    int n;
    int p;
    // R9: reset state
    setup(mk(1, 0));
    chk(divPulse == 1'b0, "R9 reset pulse", divPulse, 0);
    chk(cfgErr == 1'b0, "R9 reset err", cfgErr, 0);

    // R1 R4: sweep all legal words with M up to 8 (includes 56 and 63)
    for (int m = 1; m <= 8; m++) begin
      for (int a = 0; a <= ((m < 7) ? m : 7); a++) begin
        p = 8 * m + a;
        setup(mk(m, a));
        chk(cfgErr == 1'b0, "R5 legal word no err", cfgErr, 0);
        countTo(n, p + 20);
        chk(n == p, "R4 first pulse", n, p);
        @(negedge clk);
        chk(divPulse == 1'b0, "R3 width", divPulse, 0);
        countTo(n, p + 20);
        chk(n + 1 == p, "R1 period", n + 1, p);
        if (m == a) chk(n + 1 == 9 * m, "R2 all slow", n + 1, 9 * m);
      end
    end

    // R8: maximum ratio
    setup(mk(2047, 7));
    countTo(n, 16400);
    chk(n == 16383, "R8 first max", n, 16383);
    countTo(n, 16400);
    chk(n == 16383, "R8 period max", n, 16383);
    setup(mk(7, 1));
    countTo(n, 100);
    countTo(n, 100);
    chk(n == 57, "R8 ratio 57", n, 57);

    // R7: mid-period change to another legal word
    setup(mk(5, 2));
    countTo(n, 100);
    chk(n == 42, "R7 first", n, 42);
    repeat (10) @(negedge clk);
    word = mk(3, 1);
    countTo(n, 100);
    chk(n == 32, "R7 old period kept", n, 32);
    countTo(n, 100);
    chk(n == 25, "R7 new period", n, 25);

    // R7 R5: mid-period change to an illegal word
    repeat (5) @(negedge clk);
    word = mk(0, 0);
    countTo(n, 100);
    chk(n == 20, "R7 pulse before err", n, 20);
    chk(cfgErr == 1'b1, "R5 err at period end", cfgErr, 1);
    countTo(n, 100);
    chk(n == 100 && !divPulse, "R5 silent", n, 100);

    // R6: recovery from error
    word = mk(2, 1);
    @(negedge clk);
    chk(cfgErr == 1'b0, "R6 err cleared", cfgErr, 0);
    countTo(n, 100);
    chk(n == 17, "R6 first after recover", n, 17);

    // R5: illegal words loaded at reset
    setup(mk(3, 5));
    chk(cfgErr == 1'b1, "R5 M<A err", cfgErr, 1);
    countTo(n, 200);
    chk(n == 200 && !divPulse, "R5 M<A silent", n, 200);
    setup(mk(0, 4));
    chk(cfgErr == 1'b1, "R5 M=0 err", cfgErr, 1);
    countTo(n, 150);
    chk(n == 150 && !divPulse, "R5 M=0 silent", n, 150);

    // R9: reset in the middle of a period
    setup(mk(4, 3));
    repeat (12) @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(divPulse == 1'b0, "R9 low in reset", divPulse, 0);
    end
    rst = 1'b0;
    countTo(n, 100);
    chk(n == 35, "R9 restart after reset", n, 35);

    done = 1;
    summary();
  end

endmodule